// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Flags

This block is a purely combinational integer arithmetic logic unit of parameterised width. It is built from one identical slice per bit. Each slice holds a full adder and a small logic selector, and the adder carries ripple from the least significant slice to the most significant one. A two-bit function code selects one of four results:

- the shared add/subtract path;
- the bitwise inverse of the second operand;
- bitwise OR;
- bitwise AND.

A separate control line turns the arithmetic path from addition into subtraction. It does this by inverting every bit of the second operand and feeding a one into the lowest carry input.

Next to the result word, the unit reports three flags:

- the carry out of the top slice, as an unsigned carry indication;
- a signed overflow flag, taken as the mismatch between the carry entering and the carry leaving the top slice;
- a flag that is high whenever any result bit is set.

The unit is meant to sit in a datapath between operand registers and a result register. It has no state of its own.

Top module: `bitslice_alu`

## Requirements
- R1: With function code 0 and the subtract control low, the result is (opa + opb) modulo 2^W, and carry_out is bit W of the unrounded sum.
- R2: With function code 0 and the subtract control high, the result is (opa - opb) modulo 2^W, and carry_out is 1 exactly when opa >= opb as unsigned numbers (0 - 0 gives carry_out 1).
- R3: With function code 1 the result is the bitwise inverse of opb; neither opa nor the subtract control changes it.
- R4: With function code 2 the result is opa OR opb.
- R5: With function code 3 the result is opa AND opb.
- R6: For function code 0, ovf_flag is 1 exactly when the two's-complement result cannot be represented in W bits. This includes the most positive value plus 1 and the most negative value minus 1.
- R7: For function codes 1, 2 and 3, carry_out and ovf_flag are both 0.
- R8: nonzero is 1 exactly when at least one result bit is 1.
- R9: The width W is a parameter (default 16, any value of 2 or more).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| func_sel | input | 2 | Function code: 0 arithmetic, 1 invert opb, 2 OR, 3 AND |
| sub_en | input | 1 | Selects subtraction on the arithmetic path |
| result | output | W | Result word |
| carry_out | output | 1 | Carry out of the top slice (arithmetic only) |
| ovf_flag | output | 1 | Signed overflow (arithmetic only) |
| nonzero | output | 1 | High when any result bit is set |

## Verification
The bench goes after the signed boundaries: most positive plus one, most negative minus one, and most negative minus most positive. If the overflow were taken from the wrong carry pair, or from carry_out alone, these cases would show a missing flag or a spurious one. Subtracting zero from zero exercises the injected carry. A design that forgot the low carry-in, or did not invert opb, would return a wrong difference there, with carry_out 0. Logical codes are driven with the subtract control high and with arbitrary opa. This exposes flags that leak from the adder, and an inversion that wrongly depends on opa. An all-ones sum wrapping to zero tests the nonzero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_ARITH = 2'd0,
    FN_INVB  = 2'd1,
    FN_OR    = 2'd2,
    FN_AND   = 2'd3
  } alu_fn_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  logic    sub_i,
  input  alu_fn_e fn_i,
  output logic    q_o,
  output logic    cout_o
);
  logic b_eff;
  logic sum_bit;

  // Conditional inversion of b for subtraction, then full adder
  always_comb begin
    b_eff   = b_i ^ sub_i;
    sum_bit = a_i ^ b_eff ^ cin_i;
    cout_o  = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
  end

  always_comb begin
    unique case (fn_i)
      FN_ARITH: q_o = sum_bit;
      FN_INVB:  q_o = ~b_i;
      FN_OR:    q_o = a_i | b_i;
      FN_AND:   q_o = a_i & b_i;
      default:  q_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] q_i,
  input  logic         c_top_in_i,
  input  logic         c_top_out_i,
  input  alu_fn_e      fn_i,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         nz_o
);
  logic arith;

  always_comb begin
    arith   = (fn_i == FN_ARITH);
    carry_o = arith & c_top_out_i;
    ovf_o   = arith & (c_top_in_i ^ c_top_out_i);
    nz_o    = |q_i;
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   func_sel,
  input  logic         sub_en,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf_flag,
  output logic         nonzero
);
  localparam int MSB = W - 1;

  alu_fn_e      fn;
  logic [W:0]   chain;

  assign fn       = alu_fn_e'(func_sel);
  assign chain[0] = sub_en;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_slice u_slice (
      .a_i    (opa[i]),
      .b_i    (opb[i]),
      .cin_i  (chain[i]),
      .sub_i  (sub_en),
      .fn_i   (fn),
      .q_o    (result[i]),
      .cout_o (chain[i+1])
    );
  end

  alu_flags #(.W(W)) u_flags (
    .q_i         (result),
    .c_top_in_i  (chain[MSB]),
    .c_top_out_i (chain[W]),
    .fn_i        (fn),
    .carry_o     (carry_out),
    .ovf_o       (ovf_flag),
    .nz_o        (nonzero)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W = 16
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   func_sel,
  input logic         sub_en,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf_flag,
  input logic         nonzero
);
  logic [W:0]   wide;
  logic [W-1:0] beff;
  logic         known;

  always_comb begin
    known = !$isunknown({opa, opb, func_sel, sub_en});
    beff  = sub_en ? ~opb : opb;
    wide  = {1'b0, opa} + {1'b0, beff} + {{W{1'b0}}, sub_en};
    if (known) begin
      if (func_sel == 2'd0) begin
        // R1 and R2: arithmetic result and carry
        a_r1_arith: assert ({carry_out, result} == wide)
          else $error("arith mismatch");
        // R6: signed overflow from operand and result signs
        a_r6_ovf: assert (ovf_flag ==
            ((opa[W-1] == beff[W-1]) && (result[W-1] != opa[W-1])))
          else $error("overflow mismatch");
      end else begin
        a_r7_no_flags: assert (!carry_out && !ovf_flag)
          else $error("flags on logical op");
      end
      if (func_sel == 2'd1) begin
        a_r3_invb: assert (result == ~opb) else $error("invert mismatch");
      end
      if (func_sel == 2'd2) begin
        a_r4_or: assert (result == (opa | opb)) else $error("or mismatch");
      end
      if (func_sel == 2'd3) begin
        a_r5_and: assert (result == (opa & opb)) else $error("and mismatch");
      end
      a_r8_nonzero: assert (nonzero == (result != '0))
        else $error("nonzero mismatch");
    end
  end
endmodule

bind bitslice_alu alu_checker #(.W(W)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .func_sel  (func_sel),
  .sub_en    (sub_en),
  .result    (result),
  .carry_out (carry_out),
  .ovf_flag  (ovf_flag),
  .nonzero   (nonzero)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  localparam int W = 16;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa, opb, result;
  logic [1:0]   func_sel;
  logic         sub_en, carry_out, ovf_flag, nonzero;
  int           n_tests, n_fail;
  logic         done;

  bitslice_alu #(.W(W)) dut (
    .opa(opa), .opb(opb), .func_sel(func_sel), .sub_en(sub_en),
    .result(result), .carry_out(carry_out), .ovf_flag(ovf_flag),
    .nonzero(nonzero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected outputs: {nz, ovf, cout, result}
  function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [1:0] f, input logic s);
    logic [W-1:0] r;
    logic         c, v;
    logic signed [W+1:0] sa, sb, st;
    c = 1'b0; v = 1'b0;
    case (f)
      2'd0: begin
        sa = W'(signed'(a)) ; sb = W'(signed'(b));
        sa = {{2{a[W-1]}}, a}; sb = {{2{b[W-1]}}, b};
        st = s ? (sa - sb) : (sa + sb);
        r  = st[W-1:0];
        v  = (st > $signed({3'b000, MAXP[W-2:0]})) || (st < -$signed({3'b001, {(W-1){1'b0}}}));
        c  = s ? (a >= b) : ((({1'b0, a} + {1'b0, b}) >> W) != 0);
      end
      2'd1: r = ~b;
      2'd2: r = a | b;
      default: r = a & b;
    endcase
    return {r != '0, v, c, r};
  endfunction

  function automatic string rtag(input logic [1:0] f, input logic s);
    case (f)
      2'd0: return s ? "R2" : "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h f=%0d s=%0b)",
               req, act, exp, opa, opb, func_sel, sub_en);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] f, input logic s);
    logic [W+2:0] e;
    @(posedge clk);
    opa = a; opb = b; func_sel = f; sub_en = s;
    @(negedge clk);
    e = model(a, b, f, s);
    chk(rtag(f, s), result, e[W-1:0]);
    chk((f == 2'd0) ? (s ? "R2" : "R1") : "R7", W'(carry_out), W'(e[W]));
    chk((f == 2'd0) ? "R6" : "R7", W'(ovf_flag), W'(e[W+1]));
    chk("R8", W'(nonzero), W'(e[W+2]));
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    opa = '0; opb = '0; func_sel = 2'd0; sub_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state with zero inputs: R8 flag clear, R1 sum zero
    chk("R8", W'(nonzero), '0);
    chk("R1", result, '0);
    // Directed corners
    apply(MAXP, 16'd1, 2'd0, 1'b0);        // R6 max+1 overflows
    apply(MINN, 16'd1, 2'd0, 1'b1);        // R6 min-1 overflows
    apply(MINN, MAXP, 2'd0, 1'b1);         // R6 min-max
    apply('0, '0, 2'd0, 1'b1);             // R2 0-0: carry 1, nonzero 0
    apply('1, 16'd1, 2'd0, 1'b0);          // R1 wrap to zero, carry 1, R8
    apply(16'd3, 16'd5, 2'd0, 1'b1);       // R2 borrow: carry 0
    apply(16'h1234, 16'h00F0, 2'd1, 1'b0); // R3
    apply(16'hFFFF, 16'h00F0, 2'd1, 1'b1); // R3 opa and sub_en ignored
    apply('1, '1, 2'd1, 1'b1);             // R3 and R8: inverse zero
    apply(16'hA5A5, 16'h0F0F, 2'd2, 1'b1); // R4, R7
    apply(16'hA5A5, 16'h5A5A, 2'd3, 1'b1); // R5, R7, R8
    apply('1, '1, 2'd3, 1'b0);             // R5 all ones
    // Random stimulus across all codes (R9 default width)
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      apply(W'($urandom), W'($urandom), 2'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule